// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access at a time. Two kinds of request are answered at once, with no memory traffic. A physical-mode request passes its address straight through. A kernel superpage address is mapped directly, with one address bit relocated. Every other request walks a three-level table held in memory. The walk issues one 64-bit read per level, tests the valid and permission bits of each entry, and ends with either a physical address plus its protection bits or a fault code.

A requester offers the virtual address, the access kind, a privilege index, a physical-mode flag and the root table base. The walker answers with a one-cycle response pulse. Pages are 8 KB (13 offset bits), and each level is indexed by 10 address bits. Table reads use a valid/ready request channel and a separate response-valid strobe.

Top module: `pt_walker`

## Requirements
- R1: When req_phys_i is set, the response gives pa = va, prot = 3'b111 and code 0, with no memory read.
- R2: When the request is not physical and va bits 63:43 are not all equal, the response is code 1 (access violation) with no memory read.
- R3: A va with bit 63 set and bits 42:41 = 2'b10 is a superpage, served with no memory read. Privilege 0 gets code 0 and prot 3'b111. Its pa holds va[39:0] in bits 39:0, va[40] in bit 43, and zero in all other bits. Any other privilege gets code 1.
- R4: The walk reads the level-1 entry at base + 8*va[42:33], the level-2 entry at next + 8*va[32:23], and the level-3 entry at next + 8*va[22:13]. Here next is the previous entry's bits 63:32 shifted left by 13, and base is req_ptbase_i.
- R5: An entry with bit 0 (valid) clear, at any level, ends the walk at that level with code 2 (not valid).
- R6: A level-1 or level-2 entry that is valid but has bit 8 (kernel read enable) clear ends the walk with code 1.
- R7: Access codes are 0 read, 1 write and 2 execute. Prot bits are bit 0 read, bit 1 write and bit 2 execute. Entry bit 8+priv grants read and execute, and entry bit 12+priv grants write. A requested access with no granted permission gives code 1.
- R8: Level-3 entry bits 1, 2 and 3 remove read, write and execute from the granted set. If the requested access is removed, the code is 5 for execute, 4 for write or 3 for read, checked in that order.
- R9: A successful walk returns pa = (level-3 bits 63:32 << 13) | va[12:0] with the surviving prot. Any fault returns pa = 0 and prot = 0.
- R10: req_ready_o is low from acceptance until after the response. The response lasts one cycle. A memory request holds its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 64 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_priv_i | input | 2 | Privilege index, 0 = kernel |
| req_phys_i | input | 1 | Physical-mode bypass |
| req_ptbase_i | input | 64 | Root table base address |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_pa_o | output | 64 | Physical address |
| rsp_prot_o | output | 3 | Granted protection {exec, write, read} |
| rsp_code_o | output | 3 | 0 ok, 1 access violation, 2 not valid, 3/4/5 fault on read/write/exec |
| mem_req_valid_o | output | 1 | Table read request |
| mem_req_ready_i | input | 1 | Table read accepted |
| mem_req_addr_o | output | 64 | Table entry address |
| mem_rsp_valid_i | input | 1 | Table read data valid |
| mem_rsp_data_i | input | 64 | Table entry |

## Verification
The assertions assume that memory returns exactly one response strobe for each accepted read, and only while the walker is waiting for it. They also assume that request fields are stable in the cycle the request is accepted. The bench memory model answers one cycle after each accepted read. Its ready line toggles every cycle, so the request-hold rule is exercised. The bench only offers a new request once the previous response has been seen, so the walker is always idle at that point.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RDREQ, ST_RDWAIT, ST_DONE} walk_st_e;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_ACV  = 3'd1,
    FC_TNV  = 3'd2,
    FC_FOR  = 3'd3,
    FC_FOW  = 3'd4,
    FC_FOE  = 3'd5
  } fault_e;

  localparam int PTE_W     = 64;
  localparam int PFN_LSB   = 32;
  localparam int PTE_VALID = 0;
  localparam int PTE_FOR   = 1;
  localparam int PTE_FOE   = 3;
  localparam int PTE_KRE   = 8;
  localparam int PTE_KWE   = 12;
  localparam int PTE_LOW_W = 16;

  // superpage window and bit relocation
  localparam int SP_SEL_LO = 41;
  localparam int SP_LOW_W  = 40;
  localparam int SP_MV_SRC = 40;
  localparam int SP_MV_DST = 43;
endpackage

// File: rtl/pt_va_classify.sv
module pt_va_classify
  import pt_walker_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PRIV_W  = 2
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic              phys_i,
  input  logic [PRIV_W-1:0] priv_i,
  output logic              direct_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [2:0]        prot_o,
  output fault_e            code_o
);
  logic [VA_W-VA_IMPL-1:0] hi;
  logic sext_ok, is_sp;
  logic [PA_W-1:0] sp_pa;

  assign hi      = va_i[VA_W-1:VA_IMPL];
  assign sext_ok = (&hi) | ~(|hi);
  assign is_sp   = va_i[VA_W-1] && (va_i[SP_SEL_LO+1:SP_SEL_LO] == 2'b10);
  assign sp_pa   = PA_W'(va_i[SP_LOW_W-1:0]) | (PA_W'(va_i[SP_MV_SRC]) << SP_MV_DST);

  always_comb begin
    direct_o = 1'b1;
    pa_o     = '0;
    prot_o   = '0;
    code_o   = FC_ACV;
    if (phys_i) begin
      pa_o   = PA_W'(va_i);
      prot_o = 3'b111;
      code_o = FC_NONE;
    end else if (!sext_ok) begin
      code_o = FC_ACV;
    end else if (is_sp) begin
      if (priv_i == '0) begin
        pa_o   = sp_pa;
        prot_o = 3'b111;
        code_o = FC_NONE;
      end
    end else begin
      direct_o = 1'b0;
    end
  end
endmodule

// File: rtl/pt_perm_eval.sv
module pt_perm_eval
  import pt_walker_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic [PTE_LOW_W-1:0] pte_i,
  input  logic [1:0]           acc_i,
  input  logic [PRIV_W-1:0]    priv_i,
  output logic [2:0]           prot_o,
  output fault_e               code_o
);
  logic rd_en, wr_en;
  logic [2:0] raw, need, kept;
  logic pte_unused;

  assign pte_unused = ^pte_i[PTE_KRE-1:PTE_FOE+1];
  assign rd_en = pte_i[PTE_KRE + int'(priv_i)];
  assign wr_en = pte_i[PTE_KWE + int'(priv_i)];
  assign raw   = {rd_en, wr_en, rd_en};
  assign need  = 3'b001 << acc_i;
  assign kept  = raw & ~pte_i[PTE_FOE:PTE_FOR];

  always_comb begin
    code_o = FC_NONE;
    if (!pte_i[PTE_VALID])        code_o = FC_TNV;
    else if (~|(raw & need))      code_o = FC_ACV;
    else if (~|(kept & need))     code_o = need[2] ? FC_FOE : need[1] ? FC_FOW : FC_FOR;
    prot_o = (code_o == FC_NONE) ? kept : 3'b000;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 64,
  parameter int PG_OFS = 13,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 3,
  parameter int PRIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [1:0]        req_acc_i,
  input  logic [PRIV_W-1:0] req_priv_i,
  input  logic              req_phys_i,
  input  logic [PA_W-1:0]   req_ptbase_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic [2:0]        rsp_prot_o,
  output logic [2:0]        rsp_code_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i
);
  localparam int WALK_W = PG_OFS + IDX_W * LEVELS;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_st_e          st_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [PA_W-1:0]   base_q, pa_q;
  logic [WALK_W-1:0] va_q;
  logic [1:0]        acc_q;
  logic [PRIV_W-1:0] priv_q;
  logic [2:0]        prot_q;
  fault_e            code_q;

  logic              cls_direct;
  logic [PA_W-1:0]   cls_pa;
  logic [2:0]        cls_prot;
  fault_e            cls_code;
  logic [2:0]        fin_prot;
  fault_e            fin_code;
  logic [IDX_W-1:0]  lvl_idx [LEVELS];
  logic [IDX_W-1:0]  cur_idx;
  logic [PA_W-1:0]   frame;
  logic              rsp_unused;

  pt_va_classify #(
    .VA_W(VA_W), .PA_W(PA_W), .VA_IMPL(WALK_W), .PRIV_W(PRIV_W)
  ) u_cls (
    .va_i(req_va_i), .phys_i(req_phys_i), .priv_i(req_priv_i),
    .direct_o(cls_direct), .pa_o(cls_pa), .prot_o(cls_prot), .code_o(cls_code)
  );

  pt_perm_eval #(.PRIV_W(PRIV_W)) u_perm (
    .pte_i(mem_rsp_data_i[PTE_LOW_W-1:0]), .acc_i(acc_q), .priv_i(priv_q),
    .prot_o(fin_prot), .code_o(fin_code)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    localparam int SH = PG_OFS + IDX_W * (LEVELS - 1 - g);
    assign lvl_idx[g] = va_q[SH +: IDX_W];
  end

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < LEVELS; i++)
      if (lvl_q == LVL_W'(i)) cur_idx = lvl_idx[i];
  end

  assign rsp_unused     = ^mem_rsp_data_i[PFN_LSB-1:PTE_LOW_W];
  assign frame          = PA_W'(mem_rsp_data_i[PTE_W-1:PFN_LSB]) << PG_OFS;
  assign mem_req_addr_o = base_q + (PA_W'(cur_idx) << 3);
  assign mem_req_valid_o = (st_q == ST_RDREQ);
  assign req_ready_o    = (st_q == ST_IDLE);
  assign rsp_valid_o    = (st_q == ST_DONE);
  assign rsp_pa_o       = pa_q;
  assign rsp_prot_o     = prot_q;
  assign rsp_code_o     = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lvl_q  <= '0;
      base_q <= '0;
      va_q   <= '0;
      acc_q  <= '0;
      priv_q <= '0;
      pa_q   <= '0;
      prot_q <= '0;
      code_q <= FC_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_va_i[WALK_W-1:0];
          acc_q  <= req_acc_i;
          priv_q <= req_priv_i;
          lvl_q  <= '0;
          base_q <= req_ptbase_i;
          if (cls_direct) begin
            pa_q   <= cls_pa;
            prot_q <= cls_prot;
            code_q <= cls_code;
            st_q   <= ST_DONE;
          end else begin
            st_q <= ST_RDREQ;
          end
        end
        ST_RDREQ: if (mem_req_ready_i) st_q <= ST_RDWAIT;
        ST_RDWAIT: if (mem_rsp_valid_i) begin
          if (lvl_q == LAST_LVL) begin
            code_q <= fin_code;
            prot_q <= fin_prot;
            pa_q   <= (fin_code == FC_NONE) ? (frame | PA_W'(va_q[PG_OFS-1:0])) : '0;
            st_q   <= ST_DONE;
          end else if (!mem_rsp_data_i[PTE_VALID] || !mem_rsp_data_i[PTE_KRE]) begin
            code_q <= mem_rsp_data_i[PTE_VALID] ? FC_ACV : FC_TNV;
            prot_q <= '0;
            pa_q   <= '0;
            st_q   <= ST_DONE;
          end else begin
            base_q <= frame;
            lvl_q  <= lvl_q + 1'b1;
            st_q   <= ST_RDREQ;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic [PA_W-1:0] rsp_pa_o,
  input logic [2:0]      rsp_prot_o,
  input logic [2:0]      rsp_code_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [PA_W-1:0] mem_req_addr_o
);
  a_r10_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r10_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  a_r10_no_read_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && mem_req_valid_o));

  a_r9_fault_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o != 3'd0) |-> (rsp_prot_o == 3'd0 && rsp_pa_o == '0));

  a_r7_ok_has_prot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o == 3'd0) |-> (rsp_prot_o != 3'd0));

  a_r8_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_code_o <= 3'd5));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_pa_o(rsp_pa_o), .rsp_prot_o(rsp_prot_o),
  .rsp_code_o(rsp_code_o), .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] PTB  = 64'h0001_0000;
  localparam logic [63:0] A_L1 = 64'h0001_0028;
  localparam logic [63:0] A_L2 = 64'h0004_0038;
  localparam logic [63:0] A_L3 = 64'h0006_0048;
  localparam logic [63:0] WVA  = (64'd5 << 33) | (64'd7 << 23) | (64'd9 << 13) | 64'h1A4;
  localparam logic [63:0] WPA  = 64'h0246_81A4;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_phys = 1'b0;
  logic [63:0] req_va = '0, req_base = PTB;
  logic [1:0]  req_acc = '0, req_priv = '0;
  logic        req_ready, rsp_valid, mem_req_valid, mem_rsp_valid = 1'b0;
  logic [63:0] rsp_pa, mem_req_addr, mem_rsp_data = '0;
  logic [2:0]  rsp_prot, rsp_code;
  logic        mem_ready = 1'b0;

  bit [63:0] mem [bit [63:0]];
  int rd_cnt = 0;
  logic [63:0] addr_log [4];
  int n_tests = 0, n_fail = 0;
  logic [63:0] got_pa;
  logic [2:0]  got_prot, got_code;

  pt_walker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_acc_i(req_acc), .req_priv_i(req_priv), .req_phys_i(req_phys),
    .req_ptbase_i(req_base), .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa),
    .rsp_prot_o(rsp_prot), .rsp_code_o(rsp_code), .mem_req_valid_o(mem_req_valid),
    .mem_req_ready_i(mem_ready), .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data)
  );

  always @(negedge clk) mem_ready <= ~mem_ready;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mem_rsp_valid <= 1'b0;
    else begin
      mem_rsp_valid <= mem_req_valid && mem_ready;
      if (mem_req_valid && mem_ready) begin
        mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
        if (rd_cnt < 4) addr_log[rd_cnt] <= mem_req_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_tables(input logic [31:0] f1, input logic [31:0] f2, input logic [31:0] f3);
    mem[A_L1] = {32'h0000_0020, f1};
    mem[A_L2] = {32'h0000_0030, f2};
    mem[A_L3] = {32'h0000_1234, f3};
  endtask

  task automatic do_req(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] priv,
                        input logic phys);
    int waitc;
    logic busy;
    @(negedge clk);
    rd_cnt = 0;
    req_va = va; req_acc = acc; req_priv = priv; req_phys = phys; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0;
    while (!rsp_valid && waitc < 200) begin
      @(negedge clk);
      waitc++;
    end
    chk("R10 response arrives", 64'(rsp_valid), 64'd1);
    got_pa = rsp_pa; got_prot = rsp_prot; got_code = rsp_code; busy = req_ready;
    @(negedge clk);
    chk("R10 busy, pulse, idle again", {61'd0, busy, rsp_valid, req_ready}, 64'b001);
  endtask

  task automatic t_reset();
    chk("R10 reset idle", {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'b100);
  endtask

  task automatic t_bypass();
    do_req(64'hDEAD_BEEF_1234_5678, 2'd1, 2'd3, 1'b1);
    chk("R1 bypass pa", got_pa, 64'hDEAD_BEEF_1234_5678);
    chk("R1 bypass prot/code", {58'd0, got_prot, got_code}, {58'd0, 3'b111, 3'd0});
    chk("R1 bypass no reads", 64'(rd_cnt), 64'd0);
  endtask

  task automatic t_sext();
    do_req(64'h0000_1000_0000_0000, 2'd0, 2'd0, 1'b0);
    chk("R2 bad sign extension code", 64'(got_code), 64'd1);
    chk("R2 no reads", 64'(rd_cnt), 64'd0);
    do_req(64'h8000_0000_0000_0000, 2'd0, 2'd0, 1'b0);
    chk("R2 negative unextended code", 64'(got_code), 64'd1);
  endtask

  task automatic t_super();
    do_req(64'hFFFF_FD12_3456_789A, 2'd1, 2'd0, 1'b0);
    chk("R3 superpage pa relocated", got_pa, 64'h0000_0812_3456_789A);
    chk("R3 superpage prot/code", {58'd0, got_prot, got_code}, {58'd0, 3'b111, 3'd0});
    chk("R3 superpage no reads", 64'(rd_cnt), 64'd0);
    do_req(64'hFFFF_FC00_0000_1000, 2'd0, 2'd0, 1'b0);
    chk("R3 superpage bit40 clear", got_pa, 64'h1000);
    do_req(64'hFFFF_FD12_3456_789A, 2'd0, 2'd3, 1'b0);
    chk("R3 superpage user violation", 64'(got_code), 64'd1);
    chk("R3 user no reads", 64'(rd_cnt), 64'd0);
  endtask

  task automatic t_walk_read();
    set_tables(32'h101, 32'h101, 32'h101);
    do_req(WVA, 2'd0, 2'd0, 1'b0);
    chk("R9 walk pa", got_pa, WPA);
    chk("R7 read prot", {58'd0, got_prot, got_code}, {58'd0, 3'b101, 3'd0});
    chk("R4 three reads", 64'(rd_cnt), 64'd3);
    chk("R4 level1 address", addr_log[0], A_L1);
    chk("R4 level2 address", addr_log[1], A_L2);
    chk("R4 level3 address", addr_log[2], A_L3);
  endtask

  task automatic t_perm();
    set_tables(32'h101, 32'h101, 32'h1101);
    do_req(WVA, 2'd1, 2'd0, 1'b0);
    chk("R7 write granted", {58'd0, got_prot, got_code}, {58'd0, 3'b111, 3'd0});
    set_tables(32'h101, 32'h101, 32'h101);
    do_req(WVA, 2'd1, 2'd0, 1'b0);
    chk("R7 write denied", 64'(got_code), 64'd1);
    chk("R9 fault zeroes pa/prot", {got_pa[60:0], got_prot}, 64'd0);
    set_tables(32'h101, 32'h101, 32'h4401);
    do_req(WVA, 2'd2, 2'd2, 1'b0);
    chk("R7 priv2 shifted bits", {58'd0, got_prot, got_code}, {58'd0, 3'b111, 3'd0});
    do_req(WVA, 2'd0, 2'd0, 1'b0);
    chk("R7 priv0 lacks read", 64'(got_code), 64'd1);
  endtask

  task automatic t_tnv();
    set_tables(32'h100, 32'h101, 32'h101);
    do_req(WVA, 2'd0, 2'd0, 1'b0);
    chk("R5 level1 not valid", {got_code, 61'(rd_cnt)}, {3'd2, 61'd1});
    set_tables(32'h101, 32'h100, 32'h101);
    do_req(WVA, 2'd0, 2'd0, 1'b0);
    chk("R5 level2 not valid", {got_code, 61'(rd_cnt)}, {3'd2, 61'd2});
    set_tables(32'h101, 32'h101, 32'h1100);
    do_req(WVA, 2'd0, 2'd0, 1'b0);
    chk("R5 level3 not valid", {got_code, 61'(rd_cnt)}, {3'd2, 61'd3});
  endtask

  task automatic t_kre();
    set_tables(32'h001, 32'h101, 32'h101);
    do_req(WVA, 2'd0, 2'd0, 1'b0);
    chk("R6 level1 no kernel read", {got_code, 61'(rd_cnt)}, {3'd1, 61'd1});
    set_tables(32'h101, 32'h1001, 32'h101);
    do_req(WVA, 2'd0, 2'd0, 1'b0);
    chk("R6 level2 no kernel read", {got_code, 61'(rd_cnt)}, {3'd1, 61'd2});
  endtask

  task automatic t_faulton();
    set_tables(32'h101, 32'h101, 32'h1103);
    do_req(WVA, 2'd0, 2'd0, 1'b0);
    chk("R8 fault on read", 64'(got_code), 64'd3);
    do_req(WVA, 2'd2, 2'd0, 1'b0);
    chk("R8 exec survives read fault", {58'd0, got_prot, got_code}, {58'd0, 3'b110, 3'd0});
    set_tables(32'h101, 32'h101, 32'h1105);
    do_req(WVA, 2'd1, 2'd0, 1'b0);
    chk("R8 fault on write", 64'(got_code), 64'd4);
    set_tables(32'h101, 32'h101, 32'h110F);
    do_req(WVA, 2'd2, 2'd0, 1'b0);
    chk("R8 fault on exec", 64'(got_code), 64'd5);
    set_tables(32'h101, 32'h101, 32'h0003);
    do_req(WVA, 2'd0, 2'd0, 1'b0);
    chk("R8 violation before fault-on", 64'(got_code), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_bypass();
    t_sext();
    t_super();
    t_walk_read();
    t_perm();
    t_tnv();
    t_kre();
    t_faulton();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule